// File: doc/BRIEF.md
# Transposing Bit-Plane Input Buffer

This block holds 64 input words of 8 bits each and serves them to a bit-serial compute array one bit position at a time. Whole words are written into the buffer by entry address. Reads return one bit plane: a single chosen bit position taken from all 64 entries at once, as a 64-bit vector. Storing words whole and slicing across them on read moves the serial-parallel conversion into the storage itself. No per-entry shift registers are needed.

A plane can be requested by hand, by giving a bit index with a read strobe. A small sequencer can also walk the planes for a whole operand, starting at the most significant bit and counting down. In 8-bit mode it walks planes 7 to 0. In 4-bit mode it walks planes 3 to 0. The first plane of a sequence is flagged so that the accumulator can give the sign plane its negative weight.

The plane request is taken in on the falling clock edge. The selected plane is registered on the next rising edge.

The sequencer has two named states:
- `SEQ_IDLE` moves to `SEQ_RUN` on a start request.
- `SEQ_RUN` returns to `SEQ_IDLE` after its last plane, or at once on clear.

Top module: `bitplane_buffer`

## Requirements
- R1: While reset is asserted, the buffer drives `plane_out`, `plane_valid` and `plane_msb` to 0. After reset is released they stay at 0 until the first read.
- R2: A write with `wr_en` high stores `wr_data` into the entry chosen by `wr_addr`. The entry can later be read back through the planes: bit e of plane b equals bit b of entry e.
- R3: A manual read uses `rd_en` with index `rd_bit`. Both are driven in a cycle and taken in on that cycle's falling edge. Bit e of `plane_out` is bit `rd_bit` of entry e, and it appears at the next rising edge.
- R4: Each read makes `plane_valid` high for exactly one cycle. In a cycle without a read or a clear, `plane_out` keeps its previous value.
- R5: `seq_start` with `seq_wide`=1 (1 means 8-bit words) in `SEQ_IDLE` produces planes 7,6,…,0 on eight consecutive rising edges. The first plane arrives at the second rising edge after the cycle in which `seq_start` was driven.
- R6: `seq_start` with `seq_wide`=0 (4-bit words) produces only planes 3,2,1,0 on four consecutive edges, then returns to `SEQ_IDLE`.
- R7: `plane_msb` is high only together with the first plane of a sequence. It is 0 for every later plane and for every manual read.
- R8: While a sequence runs, `rd_en` and `seq_start` are ignored: no extra plane is produced, and the order of planes is not changed.
- R9: `clear` sets `plane_out` to 0 and `plane_valid` to 0 at the next rising edge. It overrides a pending read and stops a running sequence.
- R10: A write and a read that hit the same entry in the same cycle return the entry's old content. The new word is visible to later reads.
- R11: A change of `rd_bit` after the falling edge of a cycle has no effect on the plane produced at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests are captured on the falling edge, the output on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Entry receiving the write |
| wr_data | input | 8 | Word to store |
| rd_en | input | 1 | Manual plane read strobe |
| rd_bit | input | 3 | Bit position for a manual read |
| seq_start | input | 1 | Start an automatic plane walk from the top bit |
| seq_wide | input | 1 | Word width for the walk: 1 = 8 bits, 0 = 4 bits |
| clear | input | 1 | Zero the output register and abort any walk |
| plane_out | output | 64 | Registered bit plane, bit e from entry e |
| plane_valid | output | 1 | Plane on `plane_out` is new this cycle |
| plane_msb | output | 1 | Plane is the first (sign) plane of a walk |

## Verification
A wrong sequencer count shows up at the ports within one plane. It appears as a plane taken from the wrong bit position, or as a walk whose length is not four or eight. A corrupted storage entry shows up as a single wrong bit in every plane that reads it, so reading all eight planes after a full fill isolates the entry and bit. An output stage that captures on the wrong edge, or that reads storage after the write lands, is exposed in the same cycle by the late index change and by the same-entry write-and-read cases. A missing clear or hold is seen on the very next edge.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/tpb_store.sv
module tpb_store #(
    parameter int ENTRIES = 64,
    parameter int WORD_W  = 8,
    localparam int AW = $clog2(ENTRIES),
    localparam int BW = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [BW-1:0]      sel_bit,
    output logic [ENTRIES-1:0] plane
);
    logic [WORD_W-1:0] mem [ENTRIES];

    // Word-wide column write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Bit-row slice across every entry
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slice
            assign plane[e] = mem[e][sel_bit];
        end
    endgenerate

    // R2: the addressed entry holds the written word after the edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/tpb_seq.sv
module tpb_seq
    import tpb_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int NARROW_W = 4,
    localparam int BW = $clog2(WORD_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          seq_start,
    input  logic          seq_wide,
    output logic          busy,
    output logic [BW-1:0] idx,
    output logic          first
);
    localparam logic [BW-1:0] TOP_WIDE   = BW'(WORD_W - 1);
    localparam logic [BW-1:0] TOP_NARROW = BW'(NARROW_W - 1);

    seq_state_e    state, state_nx;
    logic [BW-1:0] cnt;
    logic          first_r;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: if (seq_start && !clear) state_nx = SEQ_RUN;
            SEQ_RUN:  if (clear || cnt == '0)  state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    // Plane counter and first-plane flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            first_r <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    cnt     <= seq_wide ? TOP_WIDE : TOP_NARROW;
                    first_r <= 1'b1;
                end
                SEQ_RUN: begin
                    cnt     <= cnt - 1'b1;
                    first_r <= 1'b0;
                end
                default: begin
                    cnt     <= '0;
                    first_r <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy  = (state == SEQ_RUN);
        idx   = cnt;
        first = (state == SEQ_RUN) && first_r;
    end

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && seq_start && !clear) |=> (busy && first));
    p_wide_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && seq_start && !clear && seq_wide) |=> idx == TOP_WIDE);
    p_narrow_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && seq_start && !clear && !seq_wide) |=> idx == TOP_NARROW);
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx != '0 && !clear) |=> (busy && !first && idx == $past(idx) - 1'b1));
    p_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx == '0) |=> !busy);
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !busy);
endmodule

// File: rtl/tpb_out.sv
module tpb_out #(
    parameter int ENTRIES = 64,
    parameter int WORD_W  = 8,
    localparam int BW = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               req_in,
    input  logic [BW-1:0]      sel_in,
    input  logic               msb_in,
    input  logic [ENTRIES-1:0] plane_in,
    output logic [BW-1:0]      sel_q,
    output logic [ENTRIES-1:0] plane_out,
    output logic               plane_valid,
    output logic               plane_msb
);
    logic req_q;
    logic msb_q;

    // Request capture on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            sel_q <= '0;
            msb_q <= 1'b0;
        end else begin
            req_q <= req_in;
            sel_q <= sel_in;
            msb_q <= msb_in;
        end
    end

    // Plane register on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plane_out   <= '0;
            plane_valid <= 1'b0;
            plane_msb   <= 1'b0;
        end else if (clear) begin
            plane_out   <= '0;
            plane_valid <= 1'b0;
            plane_msb   <= 1'b0;
        end else if (req_q) begin
            plane_out   <= plane_in;
            plane_valid <= 1'b1;
            plane_msb   <= msb_q;
        end else begin
            plane_valid <= 1'b0;
            plane_msb   <= 1'b0;
        end
    end

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (plane_out == '0 && !plane_valid));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!plane_valid && !$past(clear)) |-> $stable(plane_out));
    p_msb_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        plane_msb |-> plane_valid);
endmodule

// File: rtl/bitplane_buffer.sv
module bitplane_buffer
    import tpb_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int WORD_W   = 8,
    parameter int NARROW_W = 4,
    localparam int AW = $clog2(ENTRIES),
    localparam int BW = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [BW-1:0]      rd_bit,
    input  logic               seq_start,
    input  logic               seq_wide,
    input  logic               clear,
    output logic [ENTRIES-1:0] plane_out,
    output logic               plane_valid,
    output logic               plane_msb
);
    logic               busy;
    logic [BW-1:0]      seq_idx;
    logic               seq_first;
    logic               req;
    logic [BW-1:0]      sel;
    logic               msb;
    logic [BW-1:0]      sel_q;
    logic [ENTRIES-1:0] plane_w;

    // The sequencer owns the read path while it runs
    always_comb begin
        req = busy | rd_en;
        sel = busy ? seq_idx : rd_bit;
        msb = busy & seq_first;
    end

    tpb_seq #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .seq_start(seq_start), .seq_wide(seq_wide),
        .busy(busy), .idx(seq_idx), .first(seq_first)
    );

    tpb_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sel_bit(sel_q), .plane(plane_w)
    );

    tpb_out #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .req_in(req), .sel_in(sel), .msb_in(msb), .plane_in(plane_w),
        .sel_q(sel_q), .plane_out(plane_out),
        .plane_valid(plane_valid), .plane_msb(plane_msb)
    );

    // R7: a manual read never carries the sign flag
    p_manual_no_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy && !clear) |=> ##0 1'b1 ##0 (!plane_msb));
endmodule

// File: tb/test_bitplane_buffer.sv
module test_bitplane_buffer;
    localparam int N = 64;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         rd_en = 1'b0;
    logic [2:0]   rd_bit = '0;
    logic         seq_start = 1'b0;
    logic         seq_wide = 1'b0;
    logic         clear = 1'b0;
    logic [N-1:0] plane_out;
    logic         plane_valid;
    logic         plane_msb;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model [N];
    logic [N:0]   exp_q [$];
    logic         mon_on = 1'b0;

    always #10 clk = ~clk;

    bitplane_buffer i_bitplane_buffer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_bit(rd_bit),
        .seq_start(seq_start), .seq_wide(seq_wide), .clear(clear),
        .plane_out(plane_out), .plane_valid(plane_valid), .plane_msb(plane_msb)
    );

    task automatic check(input logic ok, input string req,
                         input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] plane_of(input int b);
        logic [N-1:0] p;
        for (int e = 0; e < N; e++) p[e] = model[e][b];
        return p;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
        wr_en = 1'b0; rd_en = 1'b0; seq_start = 1'b0; clear = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        tick();
        model[a] = d;
    endtask

    task automatic do_read(input int b);
        rd_en = 1'b1; rd_bit = 3'(b);
        exp_q.push_back({1'b0, plane_of(b)});
        tick();
    endtask

    // Monitor: compares each produced plane with the scoreboard
    always @(negedge clk) begin
        if (mon_on && plane_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R8 unexpected plane", {plane_msb, plane_out}, '0);
            end else begin
                logic [N:0] e;
                e = exp_q.pop_front();
                check({plane_msb, plane_out} === e, "R2/R3/R5/R6/R7 plane",
                      {plane_msb, plane_out}, e);
            end
        end
    end

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic run_seq(input logic wide, input int n, input logic inject);
        seq_wide = wide; seq_start = 1'b1;
        for (int k = 0; k < n; k++)
            exp_q.push_back({(k == 0), plane_of(n - 1 - k)});
        tick();
        for (int k = 0; k < n; k++) begin
            if (inject) begin rd_en = 1'b1; rd_bit = 3'd1; seq_start = 1'b1; end
            tick();
        end
    endtask

    initial begin
        for (int e = 0; e < N; e++) model[e] = '0;
        #35;
        // R1: reset state
        check(plane_out == '0 && !plane_valid && !plane_msb, "R1 in reset",
              {plane_msb, plane_out}, '0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        tick();
        check(plane_out == '0 && !plane_valid && !plane_msb, "R1 after release",
              {plane_msb, plane_out}, '0);
        mon_on = 1'b1;

        // R2/R3: fill all entries, read every plane by hand
        for (int e = 0; e < N; e++) do_write(e, 8'((e * 37 + 5) & 8'hFF));
        for (int b = 0; b < W; b++) do_read(b);
        tick();
        // R4: hold with no read
        begin
            logic [N-1:0] held;
            held = plane_out;
            tick(); tick();
            check(plane_out == held && !plane_valid, "R4 hold",
                  {plane_valid, plane_out}, {1'b0, held});
        end

        // R2: boundary entries and extreme words
        do_write(0, 8'hFF); do_write(63, 8'h80); do_write(31, 8'h00);
        do_read(7); do_read(0);
        // R10: same entry write and read in one cycle returns old data
        wr_en = 1'b1; wr_addr = 6'd63; wr_data = 8'h01;
        rd_en = 1'b1; rd_bit = 3'd7;
        exp_q.push_back({1'b0, plane_of(7)});
        tick();
        model[63] = 8'h01;
        do_read(7);   // R10: new word visible afterwards

        // R11: rd_bit changed after the falling edge is not used
        rd_en = 1'b1; rd_bit = 3'd2;
        exp_q.push_back({1'b0, plane_of(2)});
        @(negedge clk); #2;
        rd_bit = 3'd5;
        tick();
        tick();

        // R5/R7: 8-bit walk
        run_seq(1'b1, 8, 1'b0);
        // R6: 4-bit walk
        run_seq(1'b0, 4, 1'b0);
        // R8: walk with rd_en and seq_start injected
        run_seq(1'b1, 8, 1'b1);
        tick(); tick(); tick();
        check(exp_q.size() == 0 && !plane_valid, "R8 no extra planes",
              (N+1)'(exp_q.size()), '0);

        // R9: clear aborts a walk after three planes
        for (int e = 0; e < N; e += 3) do_write(e, 8'(e ^ 8'h5A));
        seq_wide = 1'b1; seq_start = 1'b1;
        for (int k = 0; k < 3; k++) exp_q.push_back({(k == 0), plane_of(7 - k)});
        tick();
        tick(); tick(); tick();
        clear = 1'b1;
        tick();
        check(plane_out == '0 && !plane_valid && !plane_msb, "R9 clear",
              {plane_msb, plane_out}, '0);
        tick(); tick(); tick();
        check(!plane_valid && exp_q.size() == 0, "R9 walk stopped",
              {plane_valid, (N)'(exp_q.size())}, '0);
        // R9: clear beats a manual read in the same cycle
        rd_en = 1'b1; rd_bit = 3'd3; clear = 1'b1;
        tick();
        check(plane_out == '0 && !plane_valid, "R9 clear over read",
              {plane_valid, plane_out}, '0);
        // R7: manual read of the top bit carries no sign flag
        do_read(7);
        tick(); tick();
        check(exp_q.size() == 0, "R3 scoreboard drained",
              (N+1)'(exp_q.size()), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule